// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A synthesizable model of a synchronous static RAM with a flow-through read path, byte-granular writes and a two-bit burst address sequencer. Address, write data, chip selects and write controls are captured on the rising clock edge. Read data is produced combinationally from the captured address in the cycle that follows, with no output register. The array is 32 bits wide, split into four 8-bit lanes; lane k occupies data bits [8k+7:8k]. The depth is 2**ADDR_W words, and a full-size instance uses ADDR_W = 16.

A cycle begins when either address strobe (`adsp_n` or `adsc_n`) is low. That cycle loads the address and clears the burst counter. In the cycles after, a low `adv_n` steps the counter, which drives the two low address bits. `mode_i` = 0 gives linear order (base + count, modulo 4). `mode_i` = 1 gives interleaved order (base XOR count). Separate `din` and `dout` ports with an active-low output enable take the place of a shared bus.

The sequencer is a three-state machine. ST_DESEL means no device is selected. ST_READ means a selected read cycle. ST_WRITE means a selected write cycle. A strobe with a failed chip select takes the edge to ST_DESEL (*deselect*). A strobe with a passed select goes to ST_WRITE when any lane is enabled (*start-write*) and to ST_READ otherwise (*start-read*). With no strobe, ST_DESEL stays put (*idle*). With no strobe, ST_READ and ST_WRITE move between each other according to the current write controls (*continue-read*, *continue-write*). Reset enters ST_DESEL.

Top module: `ft_burst_sram`

## Requirements
- R1: A word written at an address is returned on `dout` with `rd_valid` high in the cycle after the edge that captures a selected read of that address.
- R2: With `gw_n` high and `bwe_n` low, lane k (bits [8k+7:8k]) is written exactly when `bw_n[k]` is low. Other lanes keep their data.
- R3: With `gw_n` low, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R4: A selected cycle in which no lane is enabled for writing is a read cycle, and none of the stored data changes.
- R5: The device is selected only when `cs_n`=0, `cs_hi`=1 and `cs2_n`=0 at a strobe. When deselected, no write happens and `dout`=0 with `rd_valid`=0.
- R6: During a write cycle `dout` is 0 and `rd_valid` is 0.
- R7: `oe_n` high forces `dout` to 0 and `rd_valid` to 0 without waiting for a clock edge.
- R8: With `mode_i`=0, the low two address bits are base+count modulo 4. The count steps once per cycle that has `adv_n` low and no strobe, so a burst from base 1 visits 1,2,3,0.
- R9: With `mode_i`=1, the low two address bits are base XOR count, so a burst from base 2 visits 2,3,0,1.
- R10: In a cycle without a strobe and with `adv_n` high, the address is held.
- R11: Either strobe loads a new address and restarts the count at zero. `adv_n` is ignored in a strobe cycle.
- R12: After reset the device is deselected, with `rd_valid`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, captured at a strobe |
| adsp_n | input | 1 | First address strobe, active low |
| adsc_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Second chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| din | input | 32 | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dout | output | 32 | Read data, zero when not valid |
| rd_valid | output | 1 | High when `dout` carries read data |

## Verification
The hardest situation to reach is a burst that wraps its two-bit count while the write controls change from one beat to the next. In that case the lane mask, the held data and the stepped address must all refer to the same beat. The stimulus writes a four-beat linear burst with different data on each beat. It then reads the same words back in both linear and interleaved order from a base that forces a wrap. Deselected strobes, including one with `adv_n` low, are mixed in between, and the data stored under them is then read back.

// File: rtl/ftsr_pkg.sv
package ftsr_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    localparam int BURST_W = 2;

endpackage

// File: rtl/ftsr_wr_decode.sv
module ftsr_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] mask_o,
    output logic             any_o
);

    // Global write wins over the lane enables; the lane enables count only
    // while the byte-write enable is low.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_o[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
    end

    assign any_o = |mask_o;

endmodule

// File: rtl/ftsr_burst_seq.sv
module ftsr_burst_seq
    import ftsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              mode_i,
    input  logic              sel_i,
    input  logic              wr_any_i,
    input  logic [ADDR_W-1:0] addr_i,
    output seq_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - BURST_W;

    seq_state_e         st_q, st_d;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               strobe;
    logic               step;

    assign strobe = ~adsp_n | ~adsc_n;
    assign step   = (st_q != ST_DESEL) & ~strobe & ~adv_n;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DESEL: begin
                if (strobe && sel_i) st_d = wr_any_i ? ST_WRITE : ST_READ;
            end
            ST_READ, ST_WRITE: begin
                if (strobe && !sel_i) st_d = ST_DESEL;
                else                  st_d = wr_any_i ? ST_WRITE : ST_READ;
            end
            default: st_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DESEL;
        else        st_q <= st_d;
    end

    // base address and burst count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (strobe) begin
            base_q <= addr_i;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    // output process: effective address
    always_comb begin
        state_o = st_q;
        addr_o  = base_q;
        if (mode_i) addr_o[BURST_W-1:0] = base_q[BURST_W-1:0] ^ cnt_q;
        else        addr_o[BURST_W-1:0] = base_q[BURST_W-1:0] + cnt_q;
        addr_o[ADDR_W-1:BURST_W] = base_q[ADDR_W-1:BURST_W];
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr_i[ADDR_W-1:BURST_W];

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> $stable(addr_o) || $changed(mode_i));

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_DESEL && !strobe && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt_q == '0) && (base_q == $past(addr_i)));

    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel_i) |=> st_q == ST_DESEL);

endmodule

// File: rtl/ftsr_core.sv
module ftsr_core #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        // flow-through: no output register
        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram
    import ftsr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    mode_i,
    input  logic                    cs_n,
    input  logic                    cs_hi,
    input  logic                    cs2_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    rd_valid
);

    localparam int DATA_W = LANES * LANE_W;

    logic               sel;
    logic [LANES-1:0]   mask_d, mask_q, core_mask;
    logic               wr_any;
    logic [DATA_W-1:0]  din_q, rdata;
    logic [ADDR_W-1:0]  eff_addr;
    seq_state_e         st;

    assign sel = ~cs_n & cs_hi & ~cs2_n;

    ftsr_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .mask_o (mask_d),
        .any_o  (wr_any)
    );

    ftsr_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .adv_n    (adv_n),
        .mode_i   (mode_i),
        .sel_i    (sel),
        .wr_any_i (wr_any),
        .addr_i   (addr_i),
        .state_o  (st),
        .addr_o   (eff_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            din_q  <= '0;
        end else begin
            mask_q <= mask_d;
            din_q  <= din;
        end
    end

    assign core_mask = (st == ST_WRITE) ? mask_q : '0;

    ftsr_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
        .clk       (clk),
        .wr_mask_i (core_mask),
        .addr_i    (eff_addr),
        .wdata_i   (din_q),
        .rdata_o   (rdata)
    );

    always_comb begin
        rd_valid = 1'b0;
        dout     = '0;
        unique case (st)
            ST_READ: begin
                rd_valid = ~oe_n;
                dout     = oe_n ? '0 : rdata;
            end
            ST_WRITE, ST_DESEL: begin
                rd_valid = 1'b0;
                dout     = '0;
            end
            default: begin
                rd_valid = 1'b0;
                dout     = '0;
            end
        endcase
    end

    p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |-> (dout == '0 && !rd_valid));

    p_oe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dout == '0 && !rd_valid));

    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DESEL) |-> (!rd_valid && core_mask == '0));

endmodule

// File: tb/ft_burst_sram_bench.sv
module ft_burst_sram_bench;

    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam logic [2:0] SEL = 3'b010;

    typedef struct {
        logic [31:0] d;
        logic        v;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, mode_i = 1'b0;
    logic        cs_n = 1'b1, cs_hi = 1'b0, cs2_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [31:0] din = '0;
    logic        oe_n = 1'b0;
    logic [31:0] dout;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t        q[$];
    logic [31:0] shadow [1<<AW];
    logic        m_sel = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;

    always #(CLK_P/2) clk = ~clk;

    ft_burst_sram u_ft_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .mode_i(mode_i), .cs_n(cs_n),
        .cs_hi(cs_hi), .cs2_n(cs2_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .din(din), .oe_n(oe_n), .dout(dout), .rd_valid(rd_valid)
    );

    // driver: drives one cycle and pushes the expected output of it
    task automatic drv(input logic p_n, input logic c_n, input logic v_n,
                       input logic [AW-1:0] a, input logic [2:0] ce,
                       input logic g_n, input logic be_n, input logic [3:0] b_n,
                       input logic [31:0] d, input logic o_n, input logic md,
                       input string req);
        exp_t e;
        logic [3:0] mask;
        logic [AW-1:0] ea;
        @(negedge clk);
        adsp_n = p_n; adsc_n = c_n; adv_n = v_n; addr_i = a;
        {cs_n, cs_hi, cs2_n} = ce;
        gw_n = g_n; bwe_n = be_n; bw_n = b_n; din = d; oe_n = o_n; mode_i = md;
        if (!p_n || !c_n) begin
            m_sel  = (ce == SEL);
            m_base = a;
            m_cnt  = 2'd0;
        end else if (m_sel && !v_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        mask = !g_n ? 4'hF : (!be_n ? ~b_n : 4'h0);
        ea = m_base;
        ea[1:0] = md ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        e.req = req;
        if (m_sel && mask != 4'h0) begin
            e.d = '0; e.v = 1'b0;
            for (int k = 0; k < 4; k++)
                if (mask[k]) shadow[ea][k*8 +: 8] = d[k*8 +: 8];
        end else if (m_sel && !o_n) begin
            e.d = shadow[ea]; e.v = 1'b1;
        end else begin
            e.d = '0; e.v = 1'b0;
        end
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        drv(1, 1, 1, '0, SEL, 1, 1, 4'hF, '0, 0, 0, req);
    endtask

    // monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (dout !== e.d || rd_valid !== e.v) begin
                    fails++;
                    $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b",
                             e.req, dout, rd_valid, e.d, e.v);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: deselected after reset
        idle("R12");
        idle("R12");
        // R3: full-word writes, byte controls ignored
        for (int i = 0; i < 16; i++)
            drv(1, 0, 1, AW'(i), SEL, 0, 1, 4'hF, 32'h1111_1111 * (i + 1), 0, 0, "R3");
        // R1: read back
        for (int i = 0; i < 8; i++)
            drv(1, 0, 1, AW'(i), SEL, 1, 1, 4'hF, '0, 0, 0, "R1");
        // R2: lanes 0 and 2 only
        drv(1, 0, 1, 4, SEL, 1, 0, 4'b1010, 32'hDEAD_BEEF, 0, 0, "R2");
        drv(1, 0, 1, 4, SEL, 1, 1, 4'hF, '0, 0, 0, "R2");
        // R2/R4: lane enables gated off by bwe_n high -> read
        drv(1, 0, 1, 3, SEL, 1, 1, 4'h0, 32'hFFFF_FFFF, 0, 0, "R4");
        drv(1, 0, 1, 3, SEL, 1, 1, 4'hF, '0, 0, 0, "R2");
        // R4: bwe_n low but no lane chosen -> read
        drv(1, 0, 1, 5, SEL, 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, "R4");
        drv(1, 0, 1, 5, SEL, 1, 1, 4'hF, '0, 0, 0, "R4");
        // R3: global write overrides lane enables
        drv(1, 0, 1, 2, SEL, 0, 0, 4'hF, 32'h0BAD_F00D, 0, 0, "R3");
        drv(1, 0, 1, 2, SEL, 1, 1, 4'hF, '0, 0, 0, "R3");
        // R6: write cycle output quiet with oe_n low
        drv(1, 0, 1, 6, SEL, 1, 0, 4'b0111, 32'h5A5A_5A5A, 0, 0, "R6");
        // R8: linear burst from base 5 -> 5,6,7,4,5
        drv(1, 0, 1, 5, SEL, 1, 1, 4'hF, '0, 0, 0, "R8");
        for (int i = 0; i < 4; i++) drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R8");
        // R9: interleaved burst from base 6 -> 6,7,4,5
        drv(1, 0, 1, 6, SEL, 1, 1, 4'hF, '0, 0, 1, "R9");
        for (int i = 0; i < 3; i++) drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 1, "R9");
        // R10: suspend holds the address
        drv(1, 0, 1, 1, SEL, 1, 1, 4'hF, '0, 0, 0, "R10");
        drv(1, 1, 1, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R10");
        drv(1, 1, 1, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R10");
        drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R10");
        // R8: burst write 12..15 with new data each beat
        drv(1, 0, 1, 12, SEL, 0, 1, 4'hF, 32'hC0DE_0000, 0, 0, "R8");
        for (int i = 1; i < 4; i++)
            drv(1, 1, 0, '0, SEL, 0, 1, 4'hF, 32'hC0DE_0000 + i, 0, 0, "R8");
        drv(1, 0, 1, 13, SEL, 1, 1, 4'hF, '0, 0, 0, "R8");
        for (int i = 0; i < 3; i++) drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R8");
        drv(1, 0, 1, 14, SEL, 1, 1, 4'hF, '0, 0, 1, "R9");
        for (int i = 0; i < 3; i++) drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 1, "R9");
        // R11: other strobe, and strobe with adv_n low restarts the count
        drv(0, 1, 1, 7, SEL, 1, 1, 4'hF, '0, 0, 0, "R11");
        drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R11");
        drv(1, 0, 0, 2, SEL, 1, 1, 4'hF, '0, 0, 0, "R11");
        drv(1, 1, 0, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R11");
        // R5: each failing chip select blocks the write
        drv(1, 0, 1, 0, 3'b110, 0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5");
        drv(1, 1, 0, '0, 3'b110, 0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5");
        drv(1, 0, 1, 0, 3'b000, 0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5");
        drv(0, 1, 0, 0, 3'b011, 0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5");
        drv(1, 0, 1, 0, SEL, 1, 1, 4'hF, '0, 0, 0, "R5");
        // R7: output enable high masks a read
        drv(1, 0, 1, 1, SEL, 1, 1, 4'hF, '0, 1, 0, "R7");
        drv(1, 1, 1, '0, SEL, 1, 1, 4'hF, '0, 0, 0, "R7");
        idle("R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule